// File: doc/BRIEF.md
# Register Alias Table with Free-Tag Queue

This block performs register renaming for a single-issue front end. A small set of architectural register numbers is translated onto a larger pool of physical tags, so that two instructions that merely reuse the same architectural name no longer have to wait for each other. Each cycle one instruction presents two source register numbers and, optionally, a destination. The block returns the physical tags the sources currently resolve to. When there is a destination, it also returns a freshly allocated tag and the tag that the destination name pointed to until now.

Unused physical tags sit in a first-in first-out queue. A destination takes the tag at its head. When the queue is empty, any instruction that needs a destination is held off until a tag comes back. Tags come back only through the retire port. Instructions retire in program order, and each retire notice carries the destination name, the tag the instruction was given and the tag it displaced. The retire writes the given tag into a committed architectural map and pushes the displaced tag onto the tail of the queue. The caller keeps the displaced tag from rename time and hands it back at retire.

The committed map can be read one entry at a time through a query port. Value storage, operand wakeup and misprediction recovery live elsewhere.

Top module: `rename_alias_top`

## Requirements
- R1: After reset, both the speculative map and the committed map send architectural register i to physical tag i. The free queue holds tags NUM_ARCH up to NUM_PHYS-1, and it hands them out in ascending order.
- R2: The source tags are read combinationally from the speculative map. They reflect every rename accepted in earlier cycles.
- R3: An accepted instruction with a destination receives the tag at the head of the free queue on `rn_new_tag`. From the next cycle the speculative map sends that destination to the new tag.
- R4: `rn_old_tag` equals the tag the destination register mapped to before the rename.
- R5: With `rn_has_dst` low, `rn_ready` is 1 and `rn_new_tag` and `rn_old_tag` are 0. No tag is taken from the queue and the speculative map is unchanged.
- R6: With `rn_has_dst` high and the free queue empty, `rn_ready` is 0. The instruction is not accepted, and neither the speculative map nor the queue changes.
- R7: A retire with `ret_has_dst` high pushes `ret_old_tag` onto the tail of the free queue. Tags returned this way are allocated after every tag already in the queue.
- R8: A tag freed by a retire cannot be allocated in the same cycle. If the queue is empty in that cycle, `rn_ready` stays 0 for a destination, and the freed tag is allocated on the next cycle.
- R9: A retire with `ret_has_dst` high writes `ret_new_tag` into the committed map at `ret_arch`. The change is visible on `cm_tag` from the next cycle.
- R10: A retire with `ret_has_dst` low changes neither the committed map nor the free queue.
- R11: When a source register equals the destination of the same instruction, the source returns the mapping from before this instruction's rename.
- R12: An allocated tag is never one that the speculative map currently points to. The number of free tags never exceeds NUM_PHYS-NUM_ARCH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rn_valid | input | 1 | An instruction is offered for renaming |
| rn_has_dst | input | 1 | The instruction writes a destination register |
| rn_dst | input | $clog2(NUM_ARCH) | Destination architectural register |
| rn_src_a | input | $clog2(NUM_ARCH) | First source architectural register |
| rn_src_b | input | $clog2(NUM_ARCH) | Second source architectural register |
| rn_ready | output | 1 | The offered instruction is accepted this cycle |
| rn_tag_a | output | $clog2(NUM_PHYS) | Physical tag for the first source |
| rn_tag_b | output | $clog2(NUM_PHYS) | Physical tag for the second source |
| rn_new_tag | output | $clog2(NUM_PHYS) | Tag allocated to the destination |
| rn_old_tag | output | $clog2(NUM_PHYS) | Tag the destination mapped to before renaming |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_has_dst | input | 1 | The retiring instruction had a destination |
| ret_arch | input | $clog2(NUM_ARCH) | Destination architectural register of the retiring instruction |
| ret_new_tag | input | $clog2(NUM_PHYS) | Tag the retiring instruction was given |
| ret_old_tag | input | $clog2(NUM_PHYS) | Tag the retiring instruction displaced |
| cm_arch | input | $clog2(NUM_ARCH) | Committed-map query index |
| cm_tag | output | $clog2(NUM_PHYS) | Committed-map entry at `cm_arch` |

## Verification
A corrupted speculative map entry shows up on the very next source read of that register, and on `rn_old_tag` when that register is next renamed. A fault in the free-queue pointers or count appears as a wrong `rn_new_tag` on the next allocation. It can also surface as a duplicate of a live tag, or as a `rn_ready` value that is wrong when the queue drains. A bad committed-map write is visible on `cm_tag` one cycle after the retire. The bench therefore compares every output against a model on every cycle and sweeps the whole committed map after every retire.

// File: rtl/rat_pkg.sv
`timescale 1ns/10ps
package rat_pkg;
    parameter int unsigned DEF_ARCH = 8;
    parameter int unsigned DEF_PHYS = 16;

    // encoding matches {push, pop}
    typedef enum logic [1:0] {
        FL_IDLE = 2'b00,
        FL_POP  = 2'b01,
        FL_PUSH = 2'b10,
        FL_BOTH = 2'b11
    } fl_op_e;
endpackage

// File: rtl/rat_free_list.sv
`timescale 1ns/10ps
module rat_free_list
    import rat_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned NUM_PHYS = DEF_PHYS,
    localparam int unsigned TW    = $clog2(NUM_PHYS),
    localparam int unsigned DEPTH = NUM_PHYS - NUM_ARCH,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pop,
    input  logic          push,
    input  logic [TW-1:0] push_tag,
    output logic [TW-1:0] head_tag,
    output logic [CW-1:0] count,
    output logic          empty
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][TW-1:0] slot;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            cnt;
    } fl_state_t;

    fl_state_t st_d, st_q;
    fl_op_e    op;

    function automatic fl_state_t reset_state();
        fl_state_t r;
        for (int k = 0; k < DEPTH; k++) begin
            r.slot[k] = TW'(NUM_ARCH + k);
        end
        r.head = '0;
        r.tail = '0;
        r.cnt  = CW'(DEPTH);
        return r;
    endfunction

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        op   = fl_op_e'({push, pop});
        st_d = st_q;
        unique case (op)
            FL_POP: begin
                st_d.head = ptr_next(st_q.head);
                st_d.cnt  = st_q.cnt - 1'b1;
            end
            FL_PUSH: begin
                st_d.slot[st_q.tail] = push_tag;
                st_d.tail            = ptr_next(st_q.tail);
                st_d.cnt             = st_q.cnt + 1'b1;
            end
            FL_BOTH: begin
                st_d.slot[st_q.tail] = push_tag;
                st_d.tail            = ptr_next(st_q.tail);
                st_d.head            = ptr_next(st_q.head);
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign head_tag = st_q.slot[st_q.head];
    assign count    = st_q.cnt;
    assign empty    = (st_q.cnt == '0);
endmodule

// File: rtl/rat_map_table.sv
`timescale 1ns/10ps
module rat_map_table
    import rat_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned NUM_PHYS = DEF_PHYS,
    parameter int unsigned NUM_RD   = 1,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned TW = $clog2(NUM_PHYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_idx,
    input  logic [TW-1:0]                  wr_tag,
    input  logic [NUM_RD-1:0][AW-1:0]      rd_idx,
    output logic [NUM_RD-1:0][TW-1:0]      rd_tag,
    output logic [NUM_ARCH-1:0][TW-1:0]    map_all
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][TW-1:0] ent;
    } map_state_t;

    map_state_t map_d, map_q;

    function automatic map_state_t identity_map();
        map_state_t r;
        for (int i = 0; i < NUM_ARCH; i++) begin
            r.ent[i] = TW'(i);
        end
        return r;
    endfunction

    always_comb begin
        map_d = map_q;
        if (wr_en) begin
            map_d.ent[wr_idx] = wr_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q <= identity_map();
        end else begin
            map_q <= map_d;
        end
    end

    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
        assign rd_tag[r] = map_q.ent[rd_idx[r]];
    end

    assign map_all = map_q.ent;
endmodule

// File: rtl/rename_alias_top.sv
`timescale 1ns/10ps
module rename_alias_top
    import rat_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned NUM_PHYS = DEF_PHYS,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned TW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rn_valid,
    input  logic          rn_has_dst,
    input  logic [AW-1:0] rn_dst,
    input  logic [AW-1:0] rn_src_a,
    input  logic [AW-1:0] rn_src_b,
    output logic          rn_ready,
    output logic [TW-1:0] rn_tag_a,
    output logic [TW-1:0] rn_tag_b,
    output logic [TW-1:0] rn_new_tag,
    output logic [TW-1:0] rn_old_tag,
    input  logic          ret_valid,
    input  logic          ret_has_dst,
    input  logic [AW-1:0] ret_arch,
    input  logic [TW-1:0] ret_new_tag,
    input  logic [TW-1:0] ret_old_tag,
    input  logic [AW-1:0] cm_arch,
    output logic [TW-1:0] cm_tag
);
    localparam int unsigned CW       = $clog2(NUM_PHYS - NUM_ARCH + 1);
    localparam int unsigned SPEC_RD  = 3;

    logic [SPEC_RD-1:0][AW-1:0]    spec_rd_idx;
    logic [SPEC_RD-1:0][TW-1:0]    spec_rd_tag;
    logic [0:0][AW-1:0]            cm_rd_idx;
    logic [0:0][TW-1:0]            cm_rd_tag;
    logic [NUM_ARCH-1:0][TW-1:0]   spec_map_all;
    logic [NUM_ARCH-1:0][TW-1:0]   commit_map_all;
    logic                          fl_empty;
    logic [TW-1:0]                 fl_head;
    logic [CW-1:0]                 free_cnt;
    logic                          alloc_go;
    logic                          free_go;

    always_comb begin
        spec_rd_idx[0] = rn_src_a;
        spec_rd_idx[1] = rn_src_b;
        spec_rd_idx[2] = rn_dst;
        cm_rd_idx[0]   = cm_arch;

        rn_ready = !rn_has_dst || !fl_empty;
        alloc_go = rn_valid && rn_has_dst && !fl_empty;
        free_go  = ret_valid && ret_has_dst;

        rn_tag_a   = spec_rd_tag[0];
        rn_tag_b   = spec_rd_tag[1];
        rn_new_tag = rn_has_dst ? fl_head        : '0;
        rn_old_tag = rn_has_dst ? spec_rd_tag[2] : '0;
        cm_tag     = cm_rd_tag[0];
    end

    rat_map_table #(
        .NUM_ARCH(NUM_ARCH),
        .NUM_PHYS(NUM_PHYS),
        .NUM_RD  (SPEC_RD)
    ) spec_map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (alloc_go),
        .wr_idx (rn_dst),
        .wr_tag (fl_head),
        .rd_idx (spec_rd_idx),
        .rd_tag (spec_rd_tag),
        .map_all(spec_map_all)
    );

    rat_map_table #(
        .NUM_ARCH(NUM_ARCH),
        .NUM_PHYS(NUM_PHYS),
        .NUM_RD  (1)
    ) commit_map_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (free_go),
        .wr_idx (ret_arch),
        .wr_tag (ret_new_tag),
        .rd_idx (cm_rd_idx),
        .rd_tag (cm_rd_tag),
        .map_all(commit_map_all)
    );

    rat_free_list #(
        .NUM_ARCH(NUM_ARCH),
        .NUM_PHYS(NUM_PHYS)
    ) free_list_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pop     (alloc_go),
        .push    (free_go),
        .push_tag(ret_old_tag),
        .head_tag(fl_head),
        .count   (free_cnt),
        .empty   (fl_empty)
    );
endmodule

// File: rtl/rename_alias_chk.sv
`timescale 1ns/10ps
module rename_alias_chk
    import rat_pkg::*;
#(
    parameter int unsigned NUM_ARCH = DEF_ARCH,
    parameter int unsigned NUM_PHYS = DEF_PHYS,
    localparam int unsigned AW = $clog2(NUM_ARCH),
    localparam int unsigned TW = $clog2(NUM_PHYS),
    localparam int unsigned CW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rn_valid,
    input logic                        rn_has_dst,
    input logic [AW-1:0]               rn_dst,
    input logic                        rn_ready,
    input logic [TW-1:0]               rn_new_tag,
    input logic                        ret_valid,
    input logic                        ret_has_dst,
    input logic [AW-1:0]               ret_arch,
    input logic [TW-1:0]               ret_new_tag,
    input logic [NUM_ARCH-1:0][TW-1:0] spec_map,
    input logic [NUM_ARCH-1:0][TW-1:0] commit_map,
    input logic [CW-1:0]               free_cnt
);
    logic accept_dst;
    logic retire_dst;
    logic new_tag_live;

    always_comb begin
        accept_dst   = rn_valid && rn_has_dst && rn_ready;
        retire_dst   = ret_valid && ret_has_dst;
        new_tag_live = 1'b0;
        for (int i = 0; i < NUM_ARCH; i++) begin
            if (spec_map[i] == rn_new_tag) new_tag_live = 1'b1;
        end
    end

    AST_ALLOC_UPDATES_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        accept_dst |=> spec_map[$past(rn_dst)] == $past(rn_new_tag)); // R3

    AST_NO_DST_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && !rn_has_dst && !retire_dst) |=> ($stable(free_cnt) && $stable(spec_map))); // R5

    AST_EMPTY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (free_cnt == '0 && rn_has_dst) |-> !rn_ready); // R6

    AST_STALL_HOLDS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rn_valid && rn_has_dst && !rn_ready) |=> $stable(spec_map)); // R6

    AST_FREE_GROWS_ON_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_dst && !accept_dst) |=> free_cnt == $past(free_cnt) + 1'b1); // R7

    AST_COMMIT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        retire_dst |=> commit_map[$past(ret_arch)] == $past(ret_new_tag)); // R9

    AST_RET_NO_DST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !ret_has_dst) |=> $stable(commit_map)); // R10

    AST_FRESH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        accept_dst |-> !new_tag_live); // R12

    AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        free_cnt <= CW'(NUM_PHYS - NUM_ARCH)); // R12
endmodule

bind rename_alias_top rename_alias_chk #(
    .NUM_ARCH(NUM_ARCH),
    .NUM_PHYS(NUM_PHYS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rn_valid   (rn_valid),
    .rn_has_dst (rn_has_dst),
    .rn_dst     (rn_dst),
    .rn_ready   (rn_ready),
    .rn_new_tag (rn_new_tag),
    .ret_valid  (ret_valid),
    .ret_has_dst(ret_has_dst),
    .ret_arch   (ret_arch),
    .ret_new_tag(ret_new_tag),
    .spec_map   (spec_map_all),
    .commit_map (commit_map_all),
    .free_cnt   (free_cnt)
);

// File: tb/rename_alias_top_tb_top.sv
`timescale 1ns/10ps
module rename_alias_top_tb_top;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int AW = $clog2(NA);
    localparam int TW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rn_valid, rn_has_dst;
    logic [AW-1:0] rn_dst, rn_src_a, rn_src_b;
    logic          rn_ready;
    logic [TW-1:0] rn_tag_a, rn_tag_b, rn_new_tag, rn_old_tag;
    logic          ret_valid, ret_has_dst;
    logic [AW-1:0] ret_arch;
    logic [TW-1:0] ret_new_tag, ret_old_tag;
    logic [AW-1:0] cm_arch;
    logic [TW-1:0] cm_tag;

    int total = 0;
    int fails = 0;

    int spec [NA];
    int cmap [NA];
    int fl [$];
    int qd [$];
    int qn [$];
    int qo [$];
    string new_lbl = "R3";

    always #2.5 clk = ~clk;

    rename_alias_top #(.NUM_ARCH(NA), .NUM_PHYS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rn_valid(rn_valid), .rn_has_dst(rn_has_dst), .rn_dst(rn_dst),
        .rn_src_a(rn_src_a), .rn_src_b(rn_src_b), .rn_ready(rn_ready),
        .rn_tag_a(rn_tag_a), .rn_tag_b(rn_tag_b),
        .rn_new_tag(rn_new_tag), .rn_old_tag(rn_old_tag),
        .ret_valid(ret_valid), .ret_has_dst(ret_has_dst), .ret_arch(ret_arch),
        .ret_new_tag(ret_new_tag), .ret_old_tag(ret_old_tag),
        .cm_arch(cm_arch), .cm_tag(cm_tag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic sweep_commit(input string req);
        for (int i = 0; i < NA; i++) begin
            cm_arch = AW'(i);
            #0.2;
            check(int'(cm_tag) == cmap[i], req, int'(cm_tag), cmap[i]);
        end
    endtask

    // one clock cycle: drive, check outputs mid-low-phase, update model at edge
    task automatic cycle(input bit v, input bit hd, input int dst, input int sa,
                         input int sb, input bit rv, input bit rhd);
        bit exp_ready, do_ret, fire;
        int rd, rn, ro;
        string lbl;
        @(negedge clk);
        do_ret = rv && rhd && (qd.size() > 0);
        rn_valid   = v;
        rn_has_dst = hd;
        rn_dst     = AW'(dst);
        rn_src_a   = AW'(sa);
        rn_src_b   = AW'(sb);
        ret_valid  = rv;
        ret_has_dst = do_ret;
        rd = 0; rn = 0; ro = 0;
        if (do_ret) begin
            rd = qd[0]; rn = qn[0]; ro = qo[0];
        end else if (rv) begin
            rd = $urandom % NA; rn = $urandom % NP; ro = $urandom % NP;
        end
        ret_arch    = AW'(rd);
        ret_new_tag = TW'(rn);
        ret_old_tag = TW'(ro);
        #0.5;
        exp_ready = !hd || (fl.size() > 0);
        if (hd && fl.size() == 0) lbl = do_ret ? "R8" : "R6";
        else lbl = hd ? "R3" : "R5";
        check(rn_ready == exp_ready, lbl, int'(rn_ready), int'(exp_ready));
        if (v) begin
            check(int'(rn_tag_a) == spec[sa], (hd && sa == dst) ? "R11" : "R2", int'(rn_tag_a), spec[sa]);
            check(int'(rn_tag_b) == spec[sb], (hd && sb == dst) ? "R11" : "R2", int'(rn_tag_b), spec[sb]);
        end
        if (hd && exp_ready) begin
            check(int'(rn_new_tag) == fl[0], new_lbl, int'(rn_new_tag), fl[0]);
            check(int'(rn_old_tag) == spec[dst], "R4", int'(rn_old_tag), spec[dst]);
            for (int i = 0; i < NA; i++) begin
                if (spec[i] == int'(rn_new_tag)) check(1'b0, "R12", int'(rn_new_tag), -1);
            end
        end
        if (!hd) begin
            check(rn_new_tag == '0 && rn_old_tag == '0, "R5", int'(rn_new_tag) + int'(rn_old_tag), 0);
        end
        @(posedge clk);
        fire = v && exp_ready;
        if (fire && hd) begin
            qd.push_back(dst);
            qn.push_back(fl[0]);
            qo.push_back(spec[dst]);
            spec[dst] = fl.pop_front();
        end
        if (do_ret) begin
            cmap[rd] = rn;
            fl.push_back(ro);
            void'(qd.pop_front());
            void'(qn.pop_front());
            void'(qo.pop_front());
        end
        if (rv) sweep_commit(do_ret ? "R9" : "R10");
    endtask

    task automatic run();
        rst_n = 1'b0;
        rn_valid = 0; rn_has_dst = 0; rn_dst = '0; rn_src_a = '0; rn_src_b = '0;
        ret_valid = 0; ret_has_dst = 0; ret_arch = '0; ret_new_tag = '0; ret_old_tag = '0;
        cm_arch = '0;
        for (int i = 0; i < NA; i++) begin
            spec[i] = i;
            cmap[i] = i;
        end
        for (int t = NA; t < NP; t++) fl.push_back(t);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: identity maps after reset
        for (int i = 0; i < NA; i++) begin
            rn_src_a = AW'(i);
            rn_src_b = AW'(NA - 1 - i);
            cm_arch  = AW'(i);
            #0.2;
            check(int'(rn_tag_a) == i, "R1", int'(rn_tag_a), i);
            check(int'(rn_tag_b) == NA - 1 - i, "R1", int'(rn_tag_b), NA - 1 - i);
            check(int'(cm_tag) == i, "R1", int'(cm_tag), i);
        end
        // R1: first allocation is the lowest spare tag; R11 source equals destination
        new_lbl = "R1";
        cycle(1, 1, 3, 3, 3, 0, 0);
        new_lbl = "R3";
        // R2: later reader sees the new tag
        cycle(1, 1, 5, 3, 1, 0, 0);
        // R5: no-destination instructions take nothing
        cycle(1, 0, 0, 5, 3, 0, 0);
        cycle(1, 0, 2, 2, 2, 0, 0);
        // R10: retire without destination is ignored
        cycle(0, 0, 0, 0, 0, 1, 0);
        // drain the free queue, then stall (R6)
        while (fl.size() > 0) cycle(1, 1, $urandom % NA, $urandom % NA, $urandom % NA, 0, 0);
        cycle(1, 1, 4, 0, 1, 0, 0);
        cycle(1, 0, 4, 0, 1, 0, 0);
        // R8: retire while empty, allocate only the next cycle
        cycle(1, 1, 6, 6, 2, 1, 1);
        new_lbl = "R7";
        cycle(1, 1, 6, 6, 2, 0, 0);
        new_lbl = "R3";
        // retire everything in flight, then a random mix
        while (qd.size() > 0) cycle(0, 0, 0, 0, 0, 1, 1);
        for (int n = 0; n < 4000; n++) begin
            bit rv;
            rv = ($urandom % 2) == 1;
            cycle(($urandom % 4) != 0, ($urandom % 3) != 0, $urandom % NA,
                  $urandom % NA, $urandom % NA, rv, rv && (($urandom % 5) != 0));
        end
        while (qd.size() > 0) cycle(0, 0, 0, 0, 0, 1, 1);
        // R7: all tags back; a full sweep of allocations must not stall
        for (int k = 0; k < NP - NA; k++) cycle(1, 1, k % NA, 0, 0, 0, 0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (150000) @(posedge clk);
                total++;
                fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule